// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block keeps a small set of recently used page mappings so that a requester can turn a 32-bit virtual address into a 30-bit physical address without walking the page table. Pages are 4 KB. The upper 20 bits of the virtual address form the virtual page number, and the lower 12 bits pass straight through as the page offset. Each stored mapping is compared against the incoming page number at the same time. A match produces the translated address in the same cycle as the request.

When no stored mapping matches, the block raises a miss. An external page-table walker then supplies the mapping through a refill port, and the requester tries again. Each mapping carries a reference flag and a modified (dirty) flag, which the block sets as it is used. When a used or modified mapping is pushed out to make room, its page number and flags are reported to the walker for one cycle, so the page table can be brought up to date. Empty slots are filled first. Once every slot is full, a clock-hand sweep over the reference flags picks the slot to replace, which approximates least-recently-used. A flush input empties every slot.

Top module: `xlat_buffer`

## Requirements
- R1: On a hit, `paddr` equals the stored 18-bit physical page number placed above `reqVaddr[11:0]`. The page number is matched against `reqVaddr[31:12]`, and the result is available combinationally in the request's own cycle.
- R2: With `reqValid` high, exactly one of `hit` and `miss` is high, and `miss` is high when no valid slot holds the requested page number. With `reqValid` low, both are low. When there is no hit, `paddr[29:12]` is zero.
- R3: A refill stores `refillVpn`/`refillPpn` at a clock edge. A request for that page number in any later cycle then hits with that physical page.
- R4: A hit sets the slot's reference flag at the clock edge. A hit with `reqWrite` high also sets its dirty flag. A hit with `reqWrite` low leaves the dirty flag unchanged.
- R5: While any slot is empty, a refill writes the lowest-numbered empty slot and produces no write-back.
- R6: When all slots are full, a refill scans upward from a hand position, wrapping at the last slot. The hand is 0 after reset or flush. Each slot skipped has its reference flag set, and that flag is cleared. The first slot found with its reference flag clear is replaced, and the hand moves to the slot after it.
- R7: If every slot has its reference flag set, all reference flags are cleared and the slot at the hand is replaced.
- R8: When a replaced slot had its dirty or reference flag set, `wbValid` is high for exactly the cycle after the refill edge. In that cycle `wbVpn`, `wbDirty` and `wbRef` hold the slot's page number and flags as they were before the refill. Otherwise `wbValid` stays low.
- R9: A flush empties every slot and returns the hand to 0 without any write-back. A request after the flush misses.
- R10: No more than one slot matches a request, provided a refill only supplies a page number that is not already stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all slots |
| reqValid | input | 1 | Translation request present |
| reqWrite | input | 1 | Request is a store |
| reqVaddr | input | 32 | Virtual address |
| hit | output | 1 | Request matched a slot |
| miss | output | 1 | Request matched no slot |
| paddr | output | 30 | Translated physical address |
| refillValid | input | 1 | Walker supplies a mapping |
| refillVpn | input | 20 | Virtual page number of the refill |
| refillPpn | input | 18 | Physical page number of the refill |
| wbValid | output | 1 | Replaced slot's flags are reported |
| wbVpn | output | 20 | Page number of the replaced slot |
| wbDirty | output | 1 | Replaced slot was modified |
| wbRef | output | 1 | Replaced slot was referenced |

## Verification
The assertions make three assumptions about the inputs. First, the walker never supplies a page number that is already stored, which R10 relies on. Second, a refill never arrives in the same cycle as a request. Third, a flush is not raised together with a request the assertions examine. The bench respects all three. Its refill and flush tasks drop `reqValid` before raising their strobe, and every refilled page number is fresh when it is loaded. The stimulus sweeps every slot across several offsets, and then drives a scripted sequence of replacements whose victims and write-back flags are worked out by hand from R5 to R8.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = 18;
  localparam int PA_W  = PPN_W + OFF_W;

  // strobes from control to datapath
  typedef struct packed {
    logic fill;      // write the victim slot this edge
    logic evict;     // victim chosen by clock sweep (all slots full)
    logic flushAll;  // empty every slot
  } xlat_strobe_t;
endpackage

// File: rtl/xlat_ctrl.sv
`timescale 1ns/1ps
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               refillValid,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] refVec,
  output xlat_strobe_t       strobe,
  output logic [IDX_W-1:0]   victimIdx,
  output logic [ENTRIES-1:0] clrRefMask
);
  logic [IDX_W-1:0]   hand;
  logic               haveFree;
  logic [IDX_W-1:0]   freeIdx;
  logic               found;
  logic [IDX_W-1:0]   clockIdx;
  logic [ENTRIES-1:0] skipMask;
  logic [IDX_W-1:0]   scanIdx;
  int                 scanSum;

  // lowest-numbered empty slot
  always_comb begin
    haveFree = 1'b0;
    freeIdx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        haveFree = 1'b1;
        freeIdx  = IDX_W'(i);
      end
    end
  end

  // clock sweep from the hand
  always_comb begin
    found    = 1'b0;
    clockIdx = hand;
    skipMask = '0;
    scanIdx  = '0;
    scanSum  = 0;
    for (int i = 0; i < ENTRIES; i++) begin
      scanSum = (int'(hand) + i) % ENTRIES;
      scanIdx = IDX_W'(scanSum);
      if (!found) begin
        if (!refVec[scanIdx]) begin
          found    = 1'b1;
          clockIdx = scanIdx;
        end else begin
          skipMask[scanIdx] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.flushAll = flush;
    strobe.fill     = refillValid && !flush;
    strobe.evict    = refillValid && !flush && !haveFree;
    victimIdx       = haveFree ? freeIdx : clockIdx;
    clrRefMask      = strobe.evict ? skipMask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      hand <= '0;
    end else if (strobe.evict) begin
      if (int'(clockIdx) == ENTRIES - 1) hand <= '0;
      else                               hand <= clockIdx + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_datapath.sv
`timescale 1ns/1ps
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlat_strobe_t       strobe,
  input  logic [IDX_W-1:0]   victimIdx,
  input  logic [ENTRIES-1:0] clrRefMask,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic [VPN_W-1:0]   refillVpn,
  input  logic [PPN_W-1:0]   refillPpn,
  output logic [ENTRIES-1:0] hitVec,
  output logic               hit,
  output logic               miss,
  output logic [PA_W-1:0]    paddr,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] refVec,
  output logic               wbValid,
  output logic [VPN_W-1:0]   wbVpn,
  output logic               wbDirty,
  output logic               wbRef
);
  logic [VPN_W-1:0]   vpnArr [ENTRIES];
  logic [PPN_W-1:0]   ppnArr [ENTRIES];
  logic [ENTRIES-1:0] dirtyVec;
  logic [VPN_W-1:0]   reqVpn;
  logic [PPN_W-1:0]   ppnSel;

  assign reqVpn = reqVaddr[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic             slotValid;
    logic             slotRef;
    logic             slotDirty;
    logic [VPN_W-1:0] slotVpn;
    logic [PPN_W-1:0] slotPpn;
    logic             slotHit;
    logic             slotFill;

    assign slotFill = strobe.fill && (victimIdx == IDX_W'(g));
    assign slotHit  = reqValid && slotValid && (slotVpn == reqVpn);

    always_ff @(posedge clk) begin
      if (!rstN || strobe.flushAll) begin
        slotValid <= 1'b0;
        slotRef   <= 1'b0;
        slotDirty <= 1'b0;
        slotVpn   <= '0;
        slotPpn   <= '0;
      end else if (slotFill) begin
        slotValid <= 1'b1;
        slotRef   <= 1'b0;
        slotDirty <= 1'b0;
        slotVpn   <= refillVpn;
        slotPpn   <= refillPpn;
      end else begin
        if (clrRefMask[g]) slotRef <= 1'b0;
        if (slotHit) begin
          slotRef <= 1'b1;
          if (reqWrite) slotDirty <= 1'b1;
        end
      end
    end

    assign hitVec[g]   = slotHit;
    assign validVec[g] = slotValid;
    assign refVec[g]   = slotRef;
    assign dirtyVec[g] = slotDirty;
    assign vpnArr[g]   = slotVpn;
    assign ppnArr[g]   = slotPpn;
  end

  always_comb begin
    ppnSel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) ppnSel = ppnSel | ppnArr[i];
    end
  end

  assign hit   = |hitVec;
  assign miss  = reqValid && !hit;
  assign paddr = {ppnSel, reqVaddr[OFF_W-1:0]};

  // report the replaced slot one cycle after the refill edge
  always_ff @(posedge clk) begin
    if (!rstN || strobe.flushAll) begin
      wbValid <= 1'b0;
      wbVpn   <= '0;
      wbDirty <= 1'b0;
      wbRef   <= 1'b0;
    end else begin
      wbValid <= strobe.fill && validVec[victimIdx]
                 && (dirtyVec[victimIdx] || refVec[victimIdx]);
      wbVpn   <= vpnArr[victimIdx];
      wbDirty <= dirtyVec[victimIdx];
      wbRef   <= refVec[victimIdx];
    end
  end
endmodule

// File: rtl/xlat_buffer.sv
`timescale 1ns/1ps
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [VA_W-1:0]  reqVaddr,
  output logic             hit,
  output logic             miss,
  output logic [PA_W-1:0]  paddr,
  input  logic             refillValid,
  input  logic [VPN_W-1:0] refillVpn,
  input  logic [PPN_W-1:0] refillPpn,
  output logic             wbValid,
  output logic [VPN_W-1:0] wbVpn,
  output logic             wbDirty,
  output logic             wbRef
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  xlat_strobe_t       strobe;
  logic [IDX_W-1:0]   victimIdx;
  logic [ENTRIES-1:0] clrRefMask;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] refVec;
  logic [ENTRIES-1:0] hitVec;

  xlat_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .refillValid(refillValid),
    .validVec(validVec), .refVec(refVec), .strobe(strobe),
    .victimIdx(victimIdx), .clrRefMask(clrRefMask)
  );

  xlat_datapath #(.ENTRIES(ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .victimIdx(victimIdx),
    .clrRefMask(clrRefMask), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqVaddr(reqVaddr), .refillVpn(refillVpn), .refillPpn(refillPpn),
    .hitVec(hitVec), .hit(hit), .miss(miss), .paddr(paddr),
    .validVec(validVec), .refVec(refVec), .wbValid(wbValid),
    .wbVpn(wbVpn), .wbDirty(wbDirty), .wbRef(wbRef)
  );
endmodule

// File: rtl/xlat_checker.sv
`timescale 1ns/1ps
module xlat_checker
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               flush,
  input logic               reqValid,
  input logic [VA_W-1:0]    reqVaddr,
  input logic               hit,
  input logic               miss,
  input logic               refillValid,
  input logic [VPN_W-1:0]   refillVpn,
  input logic               wbValid,
  input logic [ENTRIES-1:0] hitVec,
  input logic [ENTRIES-1:0] validVec
);
  logic armed;  // one clock has passed out of reset
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  p_hit_or_miss_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (hit != miss));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!hit && !miss));

  p_single_match_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  p_refill_then_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(rstN) && $past(refillValid) && !$past(flush) && !flush
     && reqValid && (reqVaddr[VA_W-1:OFF_W] == $past(refillVpn))) |-> hit);

  p_wb_after_fill_r8: assert property (@(posedge clk) disable iff (!rstN)
    (armed && wbValid) |-> ($past(refillValid) && !$past(flush)));

  p_free_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && wbValid) |-> $past(&validVec));

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(flush) && $past(rstN)) |-> (!hit && !wbValid));
endmodule

bind xlat_buffer xlat_checker #(.ENTRIES(ENTRIES)) u_check (
  .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid),
  .reqVaddr(reqVaddr), .hit(hit), .miss(miss), .refillValid(refillValid),
  .refillVpn(refillVpn), .wbValid(wbValid), .hitVec(hitVec),
  .validVec(validVec)
);

// File: tb/tb_xlat_buffer.sv
`timescale 1ns/1ps
module tb_xlat_buffer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        hit, miss;
  logic [29:0] paddr;
  logic        refillValid = 1'b0;
  logic [19:0] refillVpn = '0;
  logic [17:0] refillPpn = '0;
  logic        wbValid;
  logic [19:0] wbVpn;
  logic        wbDirty, wbRef;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  xlat_buffer dut (
    .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqVaddr(reqVaddr), .hit(hit), .miss(miss),
    .paddr(paddr), .refillValid(refillValid), .refillVpn(refillVpn),
    .refillPpn(refillPpn), .wbValid(wbValid), .wbVpn(wbVpn),
    .wbDirty(wbDirty), .wbRef(wbRef)
  );

  always #4 clk = ~clk;

  function automatic logic [17:0] ppnOf(input logic [19:0] vpn);
    return 18'((vpn * 37) + 5);
  endfunction

  task automatic chkEq(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic [19:0] vpn, input logic [11:0] off,
                        input bit wr, input bit expHit, input string tag);
    @(negedge clk);
    refillValid = 1'b0; flush = 1'b0;
    reqValid = 1'b1; reqWrite = wr; reqVaddr = {vpn, off};
    #1;
    chkEq(tag, "hit", 64'(hit), 64'(expHit));
    chkEq(tag, "miss", 64'(miss), 64'(!expHit));
    if (expHit) chkEq(tag, "paddr", 64'(paddr), 64'({ppnOf(vpn), off}));
    else        chkEq(tag, "paddr", 64'(paddr), 64'({18'b0, off}));
  endtask

  task automatic refill(input logic [19:0] vpn, input bit expWb,
                        input logic [19:0] expVpn, input bit expD,
                        input bit expR, input string tag);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    refillValid = 1'b1; refillVpn = vpn; refillPpn = ppnOf(vpn);
    @(negedge clk);
    refillValid = 1'b0;
    #1;
    chkEq(tag, "wbValid", 64'(wbValid), 64'(expWb));
    if (expWb) begin
      chkEq(tag, "wbVpn", 64'(wbVpn), 64'(expVpn));
      chkEq(tag, "wbDirty", 64'(wbDirty), 64'(expD));
      chkEq(tag, "wbRef", 64'(wbRef), 64'(expR));
    end
  endtask

  task automatic doFlush();
    @(negedge clk);
    reqValid = 1'b0; refillValid = 1'b0; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    #1;
    chkEq("R9", "wbValid after flush", 64'(wbValid), 64'(0));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // reset state (R2, R8)
    chkEq("R2", "reset hit", 64'(hit), 64'(0));
    chkEq("R2", "reset miss", 64'(miss), 64'(0));
    chkEq("R8", "reset wbValid", 64'(wbValid), 64'(0));
    access(20'h00ABC, 12'h123, 1'b0, 1'b0, "R2 empty miss");

    // fill empty slots: no write-back (R5)
    for (int i = 0; i < 8; i++) refill(20'h100 + 20'(i), 1'b0, '0, 1'b0, 1'b0, "R5 free fill");

    // sweep every slot over several offsets (R1, R3), unmapped pages miss (R2)
    for (int i = 0; i < 8; i++) begin
      access(20'h100 + 20'(i), 12'h000, 1'b0, 1'b1, "R1 off0");
      access(20'h100 + 20'(i), 12'hFFF, 1'b0, 1'b1, "R1 offmax");
      access(20'h100 + 20'(i), 12'(i * 12'h111), 1'b0, 1'b1, "R3 offmix");
      access(20'h180 + 20'(i), 12'h5A5, 1'b0, 1'b0, "R2 unmapped");
    end
    // stores to even slots (R4)
    for (int i = 0; i < 8; i += 2) access(20'h100 + 20'(i), 12'h010, 1'b1, 1'b1, "R4 write hit");

    // all referenced: slot at hand (0) replaced, all ref cleared (R7, R8)
    refill(20'h200, 1'b1, 20'h100, 1'b1, 1'b1, "R7 full lap");
    access(20'h200, 12'h044, 1'b0, 1'b1, "R3 new page");
    access(20'h100, 12'h044, 1'b0, 1'b0, "R7 old gone");
    // hand 1: slot1 clean and unreferenced -> no write-back (R8)
    refill(20'h201, 1'b0, '0, 1'b0, 1'b0, "R8 clean evict");
    // reference slot2, then refill: skip slot2 (clear), replace slot3 (R6)
    access(20'h102, 12'h000, 1'b0, 1'b1, "R4 ref set");
    refill(20'h202, 1'b0, '0, 1'b0, 1'b0, "R6 skip referenced");
    access(20'h103, 12'h000, 1'b0, 1'b0, "R6 slot3 replaced");
    refill(20'h203, 1'b1, 20'h104, 1'b1, 1'b0, "R4 dirty kept ref cleared");
    refill(20'h204, 1'b0, '0, 1'b0, 1'b0, "R4 read-only clean");
    refill(20'h205, 1'b1, 20'h106, 1'b1, 1'b0, "R8 dirty evict");
    refill(20'h206, 1'b0, '0, 1'b0, 1'b0, "R6 wrap end");
    // hand 0: slot0 referenced -> skip; slot1 replaced (R6 wrap)
    refill(20'h207, 1'b0, '0, 1'b0, 1'b0, "R6 wrap skip");
    access(20'h201, 12'h000, 1'b0, 1'b0, "R6 slot1 replaced");
    // hand 2: slot2 ref was cleared by the skip -> reported ref 0 (R6, R8)
    refill(20'h208, 1'b1, 20'h102, 1'b1, 1'b0, "R6 skip cleared ref");
    access(20'h200, 12'h777, 1'b0, 1'b1, "R6 skipped slot kept");

    // flush (R9)
    doFlush();
    access(20'h200, 12'h777, 1'b0, 1'b0, "R9 flushed miss");
    for (int i = 0; i < 8; i++) refill(20'h300 + 20'(i), 1'b0, '0, 1'b0, 1'b0, "R9 refill after flush");
    access(20'h303, 12'h001, 1'b0, 1'b1, "R9 hit after refill");
    // hand reset to 0: slot0 replaced, not slot4 (R6, R9)
    refill(20'h310, 1'b0, '0, 1'b0, 1'b0, "R9 hand reset");
    access(20'h300, 12'h002, 1'b0, 1'b0, "R9 slot0 replaced");
    access(20'h304, 12'h003, 1'b0, 1'b1, "R9 slot4 kept");
    access(20'h310, 12'h004, 1'b1, 1'b1, "R10 single match");

    @(negedge clk);
    reqValid = 1'b0;
    #1;
    chkEq("R2", "idle hit", 64'(hit), 64'(0));
    chkEq("R2", "idle miss", 64'(miss), 64'(0));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule